// File: doc/BRIEF.md
# Character Row Line-Repeat Timing

This block generates the vertical timing of a character-cell on-screen display. It sits in the pixel clock domain and watches the horizontal and vertical sync inputs. Each sync input has a polarity bit that selects which level counts as active. After the leading edge of vertical sync it counts horizontal lines through a programmable start delay. It then walks through 15 character rows and presents, for every output line, the current row index, the font line index (0 to 17) and a flag that marks lines belonging to a character row.

Each 18-line font cell can be stretched to as many as 71 output lines. A 7-bit height code does this by emitting chosen font lines more than once. The upper two bits of the code set how many whole passes are made over the cell. The lower five bits pick nested subsets of font lines that are repeated one extra time each. A per-row double-height bit doubles every repeat count in that row. A spacing value inserts blank lines below every row. The downstream font lookup and pixel path use the row and font line outputs to address glyph data.

Top module: `vt_top`

## Requirements
- R1: Out of reset, and until the first vertical sync leading edge, row_active is 0, row_idx is 0 and font_line is 0.
- R2: A sync input is active high when its polarity bit is 1 and active low when it is 0. Only the transition into the active level (the leading edge) counts as an event.
- R3: After a vertical leading edge, the first vert_dly*4+1 horizontal lines are inactive, with row_idx 0. The line that starts at horizontal leading edge number vert_dly*4+2 is row 0, font line 0.
- R4: Within a frame, rows 0 to 14 appear in ascending order. Within a row, font lines 0 to 17 appear in ascending order, each for one or more consecutive lines, with row_active 1.
- R5: hgt_code[6:5] sets the number of whole passes: 3 for binary 11, 2 for 10, and 1 for 00 or 01. Every font line is emitted that many times before any extra repeats.
- R6: Font line n has rank (7*n) mod 18. For each set bit b of the low field (weight 2^b), font line n gets one extra emission when its rank is below 2^b. A line picked by several weights gets one extra emission for each of them.
- R7: A value of 18 or more in hgt_code[4:0] acts as 17. An undoubled row is therefore 18*passes + low-field lines tall, and never less than 18.
- R8: Bit r of row_dbl doubles the emission count of every font line in row r. Other rows are unaffected.
- R9: After every row, including row 14, row_space lines follow with row_active 0, font_line 0 and row_idx still showing that row.
- R10: Once the spacing after row 14 is over, lines stay inactive with row_idx 14 until the next vertical leading edge. A vertical leading edge at any point restarts the delay.
- R11: Outputs change only in the clock cycle after a sync leading edge. font_line is 0 on every inactive line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync, synchronous to clk |
| vsync | input | 1 | Vertical sync, synchronous to clk |
| hs_pol | input | 1 | 1: hsync active high, 0: active low |
| vs_pol | input | 1 | 1: vsync active high, 0: active low |
| vert_dly | input | VD_W (8) | Start delay in steps of four lines |
| hgt_code | input | 7 | Cell height code: [6:5] passes, [4:0] extra-repeat weights |
| row_space | input | SP_W (5) | Blank lines appended below every row |
| row_dbl | input | ROWS (15) | Per-row double-height bits, bit r for row r |
| row_idx | output | RW (4) | Current character row |
| font_line | output | 5 | Current font line within the cell |
| row_active | output | 1 | High on lines that belong to a character row |

## Verification
The assertions assume that both syncs are synchronous to clk and that leading edges of the same sync are at least two clocks apart. They also assume that a vertical and a horizontal leading edge never fall in the same cycle, and that hgt_code and row_dbl stay still while rows are being drawn. The bench drives each line as a fixed six-clock pattern and separates vertical pulses from line pulses by whole clocks. It changes the polarity bits, the height code and the row settings only between frames, while the block is idle or in front of a vertical edge. Random frames keep the delay short so that many height codes, spacings and double-height masks fit in the run. Directed frames cover the longest delay, the clamp of the low field, both polarities and a restart in the middle of a frame.

// File: rtl/vt_pkg.sv
package vt_pkg;

  localparam int FONT_LINES = 18;
  localparam int FL_W       = 5;
  localparam int LEN_W      = 5;
  localparam int LOW_MAX    = 17;

  typedef enum logic [1:0] {
    VT_IDLE  = 2'd0,
    VT_DELAY = 2'd1,
    VT_ROW   = 2'd2,
    VT_SPACE = 2'd3
  } vt_state_e;

  // Rank of a font line in the nested repeat order: ranks spread evenly.
  function automatic int line_rank(input logic [FL_W-1:0] n);
    return (int'(n) * 7) % FONT_LINES;
  endfunction

  // Whole passes over the cell from the upper pair of the height code.
  function automatic logic [1:0] whole_passes(input logic [1:0] hi);
    return hi[1] ? (hi[0] ? 2'd3 : 2'd2) : 2'd1;
  endfunction

  // Low field clamp: 18 and above act as 17.
  function automatic logic [4:0] low_weight(input logic [4:0] lo);
    return (lo >= 5'd18) ? 5'(LOW_MAX) : lo;
  endfunction

  // Extra emissions of one font line: one per selected weight covering it.
  function automatic logic [2:0] extra_reps(input logic [FL_W-1:0] n,
                                            input logic [4:0] w);
    int acc;
    acc = 0;
    for (int b = 0; b < 5; b++) begin
      if (w[b] && (line_rank(n) < (1 << b))) acc++;
    end
    return 3'(acc);
  endfunction

endpackage

// File: rtl/vt_edge_det.sv
module vt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic act_high,
  output logic lead
);
  logic lvl, lvl_q;

  assign lvl = pin ~^ act_high;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign lead = lvl & ~lvl_q;
endmodule

// File: rtl/vt_line_weight.sv
module vt_line_weight
  import vt_pkg::*;
(
  input  logic [FL_W-1:0]  fline,
  input  logic [6:0]       hgt,
  input  logic             dbl,
  output logic [LEN_W-1:0] line_len
);
  logic [LEN_W-1:0] base;

  always_comb begin
    base = LEN_W'(whole_passes(hgt[6:5]))
         + LEN_W'(extra_reps(fline, low_weight(hgt[4:0])));
    line_len = dbl ? (base << 1) : base;
  end
endmodule

// File: rtl/vt_top.sv
module vt_top
  import vt_pkg::*;
#(
  parameter  int ROWS = 15,
  parameter  int VD_W = 8,
  parameter  int SP_W = 5,
  localparam int RW   = $clog2(ROWS),
  localparam int DLY_W = VD_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsync,
  input  logic            vsync,
  input  logic            hs_pol,
  input  logic            vs_pol,
  input  logic [VD_W-1:0] vert_dly,
  input  logic [6:0]      hgt_code,
  input  logic [SP_W-1:0] row_space,
  input  logic [ROWS-1:0] row_dbl,
  output logic [RW-1:0]   row_idx,
  output logic [FL_W-1:0] font_line,
  output logic            row_active
);
  // Line and frame events, brought out for the checker.
  logic hs_evt, vs_evt;

  vt_edge_det u_hs (.clk(clk), .rst_n(rst_n), .pin(hsync), .act_high(hs_pol), .lead(hs_evt));
  vt_edge_det u_vs (.clk(clk), .rst_n(rst_n), .pin(vsync), .act_high(vs_pol), .lead(vs_evt));

  vt_state_e        state;
  logic [DLY_W-1:0] dly_cnt;
  logic [RW-1:0]    row_q;
  logic [FL_W-1:0]  fline_q;
  logic [LEN_W-1:0] rep_q;
  logic [SP_W-1:0]  sp_q;
  logic [LEN_W-1:0] line_len;

  logic [DLY_W-1:0] dly_target;
  logic             last_rep, last_fline, last_row, delay_done, space_done;

  vt_line_weight u_weight (
    .fline   (fline_q),
    .hgt     (hgt_code),
    .dbl     (row_dbl[row_q]),
    .line_len(line_len)
  );

  assign dly_target = DLY_W'({vert_dly, 2'b00}) + DLY_W'(1);
  assign last_rep   = (rep_q == line_len - 1'b1);
  assign last_fline = (fline_q == FL_W'(FONT_LINES - 1));
  assign last_row   = (row_q == RW'(ROWS - 1));
  assign delay_done = (dly_cnt == dly_target);
  assign space_done = (sp_q == row_space);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= VT_IDLE;
      dly_cnt <= '0;
      row_q   <= '0;
      fline_q <= '0;
      rep_q   <= '0;
      sp_q    <= '0;
    end else if (vs_evt) begin
      state   <= VT_DELAY;
      dly_cnt <= '0;
      row_q   <= '0;
      fline_q <= '0;
      rep_q   <= '0;
      sp_q    <= '0;
    end else if (hs_evt) begin
      case (state)
        VT_DELAY: begin
          if (delay_done) state <= VT_ROW;
          else            dly_cnt <= dly_cnt + 1'b1;
        end
        VT_ROW: begin
          if (!last_rep) begin
            rep_q <= rep_q + 1'b1;
          end else begin
            rep_q <= '0;
            if (!last_fline) begin
              fline_q <= fline_q + 1'b1;
            end else begin
              fline_q <= '0;
              if (row_space != '0) begin
                state <= VT_SPACE;
                sp_q  <= SP_W'(1);
              end else if (last_row) begin
                state <= VT_IDLE;
              end else begin
                row_q <= row_q + 1'b1;
              end
            end
          end
        end
        VT_SPACE: begin
          if (!space_done) begin
            sp_q <= sp_q + 1'b1;
          end else if (last_row) begin
            state <= VT_IDLE;
          end else begin
            state <= VT_ROW;
            row_q <= row_q + 1'b1;
          end
        end
        default: state <= VT_IDLE;
      endcase
    end
  end

  assign row_idx    = row_q;
  assign font_line  = fline_q;
  assign row_active = (state == VT_ROW);
endmodule

// File: rtl/vt_top_chk.sv
module vt_top_chk
  import vt_pkg::*;
#(
  parameter int ROWS = 15,
  parameter int RW   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hs_evt,
  input logic             vs_evt,
  input vt_state_e        state,
  input logic             row_active,
  input logic [RW-1:0]    row_idx,
  input logic [FL_W-1:0]  font_line,
  input logic [LEN_W-1:0] rep_q,
  input logic [LEN_W-1:0] line_len
);
  // R4: row and font line stay inside the cell grid
  a_r4_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx <= RW'(ROWS - 1));
  a_r4_fline_range: assert property (@(posedge clk) disable iff (!rst_n)
    font_line <= FL_W'(FONT_LINES - 1));

  // R11: nothing moves without a sync event
  a_r11_still_between_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_evt && !vs_evt) |=> ($stable(row_active) && $stable(row_idx) && $stable(font_line)));

  // R11: inactive lines carry font line 0
  a_r11_inactive_fline: assert property (@(posedge clk) disable iff (!rst_n)
    !row_active |-> (font_line == '0));

  // R10: a vertical event always restarts in the delay
  a_r10_vsync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    vs_evt |=> (!row_active && (row_idx == '0) && (font_line == '0)));

  // R10: the finished frame stays quiet until the next vertical event
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == VT_IDLE) && !vs_evt) |=> ((state == VT_IDLE) && !row_active));

  // R6: the repeat counter never runs past the emission count
  a_r6_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == VT_ROW) |-> (rep_q < line_len));
endmodule

bind vt_top vt_top_chk #(.ROWS(ROWS), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_evt    (hs_evt),
  .vs_evt    (vs_evt),
  .state     (state),
  .row_active(row_active),
  .row_idx   (row_idx),
  .font_line (font_line),
  .rep_q     (rep_q),
  .line_len  (line_len)
);

// File: tb/sim_vt_top.sv
module sim_vt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsync, vsync, hs_pol, vs_pol;
  logic [7:0]  vert_dly;
  logic [6:0]  hgt_code;
  logic [4:0]  row_space;
  logic [14:0] row_dbl;
  logic [3:0]  row_idx;
  logic [4:0]  font_line;
  logic        row_active;

  int n_run = 0;
  int n_fail = 0;
  int lines_left = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vt_top u0 (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .vert_dly(vert_dly),
    .hgt_code(hgt_code), .row_space(row_space), .row_dbl(row_dbl),
    .row_idx(row_idx), .font_line(font_line), .row_active(row_active)
  );

  task automatic check_out(input int ea, input int er, input int ef, input string tag);
    n_run++;
    if (row_active !== 1'(ea) || int'(row_idx) != er || int'(font_line) != ef) begin
      n_fail++;
      $display("FAIL %s: active/row/line got %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, row_active, row_idx, font_line, ea, er, ef);
    end
  endtask

  // Rank through the inverse step (13 undoes 7 modulo 18).
  function automatic int b_rank(input int n);
    for (int p = 0; p < 18; p++) if (((p * 13) % 18) == n) return p;
    return 99;
  endfunction

  function automatic int b_len(input int n, input int code, input bit d);
    int hi, lo, x;
    hi = (code >> 5) & 3;
    x  = (hi == 3) ? 3 : (hi == 2) ? 2 : 1;
    lo = code & 31;
    if (lo > 17) lo = 17;
    for (int w = 1; w <= 16; w = w * 2)
      if (((lo & w) != 0) && (b_rank(n) < w)) x++;
    return d ? 2 * x : x;
  endfunction

  task automatic idle_pins();
    @(negedge clk);
    hsync = ~hs_pol;
    vsync = ~vs_pol;
  endtask

  task automatic hline(input int ea, input int er, input int ef, input string tag);
    if (lines_left <= 0) return;
    lines_left--;
    @(negedge clk); hsync = hs_pol;
    @(negedge clk);
    @(negedge clk); hsync = ~hs_pol;
    @(negedge clk);
    check_out(ea, er, ef, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic vpulse();
    @(negedge clk); vsync = vs_pol;
    @(negedge clk);
    @(negedge clk); vsync = ~vs_pol;
    @(negedge clk);
  endtask

  task automatic frame(input int vd, input int code, input logic [14:0] dbl,
                       input int sp, input int limit, input string ftag, input string dtag);
    vert_dly  = 8'(vd);
    hgt_code  = 7'(code);
    row_dbl   = dbl;
    row_space = 5'(sp);
    vpulse();
    lines_left = limit;
    for (int i = 0; i < vd * 4 + 1; i++) hline(0, 0, 0, {dtag, " delay"});
    for (int r = 0; r < 15; r++) begin
      for (int n = 0; n < 18; n++)
        for (int j = 0; j < b_len(n, code, dbl[r]); j++) hline(1, r, n, ftag);
      for (int s = 0; s < sp; s++) hline(0, r, 0, "R9 spacing");
    end
    for (int i = 0; i < 4; i++) hline(0, 14, 0, "R10 after last row");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; hs_pol = 1'b1; vs_pol = 1'b1; hsync = 1'b0; vsync = 1'b0;
    vert_dly = 8'd4; hgt_code = '0; row_space = '0; row_dbl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out(0, 0, 0, "R1 reset");
    lines_left = 2;
    hline(0, 0, 0, "R1 before first frame");
    hline(0, 0, 0, "R1 before first frame");

    // Plain cell, no delay steps
    frame(0, 0, 15'h0000, 0, 100000, "R4 R5 base", "R3");
    // Code 2: 20-line cell
    frame(4, 2, 15'h0000, 0, 100000, "R4 R6 code2", "R3");
    // Clamped low field, three passes, alternate doubled rows, wide spacing
    frame(3, 127, 15'h5555, 31, 100000, "R4 R7 R8 clamp", "R3");
    // Active-low syncs, longest delay, two passes
    hs_pol = 1'b0; vs_pol = 1'b0; idle_pins();
    frame(255, 7'h40, 15'h0000, 2, 100000, "R2 R5 low polarity", "R2 R3");
    // Restart in the middle of a frame
    hs_pol = 1'b1; vs_pol = 1'b1; idle_pins();
    frame(1, 7'h25, 15'h0003, 1, 50, "R4 R6 cut", "R3");
    frame(1, 7'h25, 15'h0003, 1, 100000, "R10 R4 restarted", "R10 R3");
    // Random frames
    for (int k = 0; k < 4; k++) begin
      hs_pol = 1'($urandom); vs_pol = 1'($urandom); idle_pins();
      frame(int'($urandom % 8), int'($urandom % 128), 15'($urandom),
            int'($urandom % 32), 100000, "R2 R4 R6 R7 R8 random", "R3");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule